// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control unit of a small single-accumulator machine. It runs every machine instruction as a short routine of micro-operations. An instruction word arrives on a valid/ready stream and is latched into a holding register. The opcode bits of that word pick the first entry of a routine in a microcode ROM inside the block. A micro-program counter then steps through that routine one control word per cycle. Each control word drives the datapath directly: it can drive the data-memory address, route the read bus into the accumulator, enable a bus read or write, update the status flags, or load the program counter. A control word carrying the end-of-instruction bit finishes the routine, and the block returns to accepting the next instruction.

The instruction is 8 bits wide: a 4-bit opcode in the upper half and a 4-bit operand address in the lower half. A routine starts at micro-address `opcode << 3`, so each opcode owns eight micro-words. The data memory is outside the block. Its read data is combinational, which means `dmem_rdata` must reflect `dmem_addr` within the same cycle. A write is performed at the rising edge during which `dmem_wr` is high.

Back-pressure rules for the instruction stream are as follows. `ins_ready` is high only while the block is waiting for an instruction. A word is taken on a rising edge where both `ins_valid` and `ins_ready` are high. While `ins_ready` is low, the source must keep the word it intends to send, and the block ignores `ins_valid` and `ins_data`. `fetch_pc` gives the address of the instruction the source should present next.

Top module: `useq_core`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are `acc` = 0, `zero_flag` = 0, `neg_flag` = 0, `fetch_pc` = 0 and `ins_ready` = 1. The first instruction requested is therefore the one at address 0.
- R2: The block takes an instruction only on a cycle where `ins_valid` and `ins_ready` are both high. Taking an instruction advances `fetch_pc` by one, modulo 16.
- R3: The opcode, instruction bits [7:4], selects a routine starting at micro-address opcode×8. `ins_ready` stays low for exactly the routine length: LOAD (opcode 1), ADD (3), SUB (5) and AND (6) take 4 cycles; STORE (2) takes 3 cycles; JUMP (4), NOP (0) and unused opcodes take 1 cycle.
- R4: LOAD sets `acc` to the memory word at the address field, instruction bits [3:0]. The routine drives the address, then routes the bus to the accumulator, then reads, then ends. `dmem_rd` is high for exactly one cycle per LOAD, ADD, SUB or AND, and never for the other opcodes.
- R5: STORE writes `acc` to the memory word at the address field. `dmem_wr` is high for exactly one cycle. STORE changes neither `acc` nor the flags.
- R6: ADD, SUB and AND set `acc` to acc+mem, acc−mem or acc&mem, each taken modulo 256.
- R7: `zero_flag` is set when the new accumulator value is 0, and `neg_flag` copies its bit 7. Both flags change only on the read step of LOAD, ADD, SUB and AND. They hold through STORE, JUMP, NOP and unused opcodes.
- R8: JUMP sets `fetch_pc` to the address field.
- R9: Opcodes 7 to 15 act as a one-cycle no-operation. They leave `acc`, the flags and memory unchanged, and `fetch_pc` only advances by one.
- R10: `dmem_addr` equals the address field whenever a micro-word drives the address, and is 0 otherwise. `dmem_rd` and `dmem_wr` are asserted only while the address is driven.
- R11: While the block is busy (`ins_ready` low), any `ins_valid`/`ins_data` is ignored. While it is idle with `ins_valid` low, `acc`, the flags and `fetch_pc` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block can take an instruction this cycle |
| ins_data | input | 8 | Instruction: opcode [7:4], address field [3:0] |
| fetch_pc | output | 4 | Address of the next instruction to present |
| dmem_addr | output | 4 | Data-memory address |
| dmem_rd | output | 1 | Data-memory read enable |
| dmem_rdata | input | 8 | Data-memory read data (combinational) |
| dmem_wr | output | 1 | Data-memory write enable |
| dmem_wdata | output | 8 | Data-memory write data (accumulator) |
| acc | output | 8 | Accumulator |
| zero_flag | output | 1 | Status: last loaded/computed value was zero |
| neg_flag | output | 1 | Status: bit 7 of last loaded/computed value |

## Verification
The bench builds the block with its default parameters: a 4-bit opcode and a 4-bit address field, eight micro-words per routine, an 8-bit accumulator and a 4-bit program counter. With a 16-word data space, random addresses revisit stored words often, so a STORE followed by a LOAD is exercised many times. The narrow accumulator makes carry wrap, zero results and sign changes frequent. Random opcodes cover all sixteen routine bases, including the unused ones, and the program counter wraps repeatedly. Directed cases cover the zero result of an ADD that wraps, a negative SUB result, and a JUMP to the top address.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_AND  = 2'd3
  } alu_op_e;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXEC  = 1'b1
  } seq_state_e;

  // One control word of the microcode store
  typedef struct packed {
    logic    addr_drive;
    logic    bus_to_acc;
    logic    rd_en;
    logic    wr_en;
    logic    set_status;
    logic    pc_load;
    logic    end_inst;
    alu_op_e alu;
  } uword_t;

  localparam int unsigned OP_NOP   = 0;
  localparam int unsigned OP_LOAD  = 1;
  localparam int unsigned OP_STORE = 2;
  localparam int unsigned OP_ADD   = 3;
  localparam int unsigned OP_JUMP  = 4;
  localparam int unsigned OP_SUB   = 5;
  localparam int unsigned OP_AND   = 6;

  // Control word at step 'slot' of the routine for opcode 'opc'.
  // Slots beyond a routine's end hold a bare end marker.
  function automatic uword_t ucode_word(input int unsigned opc, input int unsigned slot);
    uword_t w;
    w = '0;
    case (opc)
      OP_LOAD, OP_ADD, OP_SUB, OP_AND: begin
        case (opc)
          OP_ADD:  w.alu = ALU_ADD;
          OP_SUB:  w.alu = ALU_SUB;
          OP_AND:  w.alu = ALU_AND;
          default: w.alu = ALU_PASS;
        endcase
        case (slot)
          0: w.addr_drive = 1'b1;
          1: begin
            w.addr_drive = 1'b1;
            w.bus_to_acc = 1'b1;
          end
          2: begin
            w.addr_drive = 1'b1;
            w.bus_to_acc = 1'b1;
            w.rd_en      = 1'b1;
            w.set_status = 1'b1;
          end
          default: w.end_inst = 1'b1;
        endcase
      end
      OP_STORE: begin
        case (slot)
          0: w.addr_drive = 1'b1;
          1: begin
            w.addr_drive = 1'b1;
            w.wr_en      = 1'b1;
          end
          default: w.end_inst = 1'b1;
        endcase
      end
      OP_JUMP: begin
        w.pc_load  = 1'b1;
        w.end_inst = 1'b1;
      end
      default: w.end_inst = 1'b1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic [OPC_W+SLOT_W-1:0] addr,
  output uword_t                  word
);
  localparam int UPC_W = OPC_W + SLOT_W;
  localparam int DEPTH = 1 << UPC_W;
  localparam int SLOTS = 1 << SLOT_W;

  uword_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign tbl[g] = ucode_word(g / SLOTS, g % SLOTS);
  end

  assign word = tbl[addr];

endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int ADR_W  = 4,
  parameter int SLOT_W = 3,
  parameter int PC_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_valid,
  output logic                    ins_ready,
  input  logic [OPC_W+ADR_W-1:0]  ins_data,
  input  uword_t                  uw,
  output logic [OPC_W+SLOT_W-1:0] upc,
  output logic [ADR_W-1:0]        op_addr,
  output logic [PC_W-1:0]         pc
);
  localparam int INS_W = OPC_W + ADR_W;

  seq_state_e       st;
  logic [INS_W-1:0] ir;
  logic             take;

  assign ins_ready = (st == ST_FETCH);
  assign take      = ins_valid && ins_ready;
  assign op_addr   = ir[ADR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_FETCH;
      ir  <= '0;
      upc <= '0;
      pc  <= '0;
    end else begin
      case (st)
        ST_FETCH: begin
          if (take) begin
            ir  <= ins_data;
            upc <= {ins_data[INS_W-1 -: OPC_W], {SLOT_W{1'b0}}};
            pc  <= pc + PC_W'(1);
            st  <= ST_EXEC;
          end
        end
        default: begin
          if (uw.pc_load) pc <= PC_W'(ir[ADR_W-1:0]);
          if (uw.end_inst) st <= ST_FETCH;
          else             upc <= upc + 1'b1;
        end
      endcase
    end
  end

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc == $past(pc) + PC_W'(1));

  a_r3_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> upc[OPC_W+SLOT_W-1 -: OPC_W] == ir[INS_W-1 -: OPC_W] && upc[SLOT_W-1:0] == '0);

  a_r3_no_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_ready && !uw.end_inst) |-> upc[SLOT_W-1:0] != {SLOT_W{1'b1}});

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && !ins_valid) |=> ins_ready && $stable(pc) && $stable(ir));

  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |=> $stable(ir));

endmodule

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              load_en,
  input  logic              set_status,
  input  alu_op_e           alu,
  output logic [DATA_W-1:0] acc,
  output logic              zf,
  output logic              nf
);
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    case (alu)
      ALU_ADD: alu_y = acc + bus_in;
      ALU_SUB: alu_y = acc - bus_in;
      ALU_AND: alu_y = acc & bus_in;
      default: alu_y = bus_in;
    endcase
    nxt = load_en ? alu_y : acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      zf  <= 1'b0;
      nf  <= 1'b0;
    end else begin
      acc <= nxt;
      if (set_status) begin
        zf <= (nxt == '0);
        nf <= nxt[DATA_W-1];
      end
    end
  end

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_status |=> $stable(zf) && $stable(nf));

  a_r7_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    set_status |=> zf == (acc == '0));

  a_r7_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    set_status |=> nf == acc[DATA_W-1]);

  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(acc));

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int ADR_W  = 4,
  parameter int SLOT_W = 3,
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_valid,
  output logic                   ins_ready,
  input  logic [OPC_W+ADR_W-1:0] ins_data,
  output logic [PC_W-1:0]        fetch_pc,
  output logic [ADR_W-1:0]       dmem_addr,
  output logic                   dmem_rd,
  input  logic [DATA_W-1:0]      dmem_rdata,
  output logic                   dmem_wr,
  output logic [DATA_W-1:0]      dmem_wdata,
  output logic [DATA_W-1:0]      acc,
  output logic                   zero_flag,
  output logic                   neg_flag
);
  localparam int UPC_W = OPC_W + SLOT_W;

  logic [UPC_W-1:0] upc;
  logic [ADR_W-1:0] op_addr;
  uword_t           rom_w;
  uword_t           uw;

  useq_rom #(.OPC_W(OPC_W), .SLOT_W(SLOT_W)) u_rom (
    .addr (upc),
    .word (rom_w)
  );

  // Control words act only while a routine is running
  assign uw = ins_ready ? '0 : rom_w;

  useq_seq #(.OPC_W(OPC_W), .ADR_W(ADR_W), .SLOT_W(SLOT_W), .PC_W(PC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_data  (ins_data),
    .uw        (uw),
    .upc       (upc),
    .op_addr   (op_addr),
    .pc        (fetch_pc)
  );

  useq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_in     (dmem_rdata),
    .load_en    (uw.bus_to_acc && uw.rd_en),
    .set_status (uw.set_status),
    .alu        (uw.alu),
    .acc        (acc),
    .zf         (zero_flag),
    .nf         (neg_flag)
  );

  assign dmem_addr  = uw.addr_drive ? op_addr : '0;
  assign dmem_rd    = uw.rd_en;
  assign dmem_wr    = uw.wr_en;
  assign dmem_wdata = acc;

  a_r10_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |-> uw.addr_drive && dmem_addr == op_addr);

  a_r10_wr_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |-> uw.addr_drive && dmem_addr == op_addr);

  a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |=> !dmem_rd);

  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |=> !dmem_wr);

  a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && ins_valid) |=> !ins_ready);

endmodule

// File: tb/useq_core_bench.sv
module useq_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ins_valid = 1'b0;
  logic [7:0] ins_data = '0;
  logic       ins_ready;
  logic [3:0] fetch_pc;
  logic [3:0] dmem_addr;
  logic       dmem_rd;
  logic       dmem_wr;
  logic [7:0] dmem_rdata;
  logic [7:0] dmem_wdata;
  logic [7:0] acc;
  logic       zero_flag;
  logic       neg_flag;

  always #2 clk = ~clk;

  // external data memory with a preload port for the bench
  logic [7:0] ext_mem [16];
  logic       pre_we = 1'b0;
  logic [3:0] pre_a = '0;
  logic [7:0] pre_d = '0;
  assign dmem_rdata = ext_mem[dmem_addr];
  always @(posedge clk) begin
    if (pre_we) ext_mem[pre_a] <= pre_d;
    else if (dmem_wr) ext_mem[dmem_addr] <= dmem_wdata;
  end

  useq_core u_useq_core (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .fetch_pc(fetch_pc), .dmem_addr(dmem_addr),
    .dmem_rd(dmem_rd), .dmem_rdata(dmem_rdata), .dmem_wr(dmem_wr),
    .dmem_wdata(dmem_wdata), .acc(acc), .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  int total = 0;
  int bad = 0;

  logic [7:0] m_acc;
  logic       m_z, m_n;
  logic [3:0] m_pc;
  logic [7:0] m_mem [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int opc);
    case (opc)
      1, 3, 5, 6: return 4;
      2:          return 3;
      default:    return 1;
    endcase
  endfunction

  function automatic bit is_read_op(input int opc);
    return opc == 1 || opc == 3 || opc == 5 || opc == 6;
  endfunction

  task automatic run_ins(input logic [7:0] ins, input int gap);
    int cnt, rdc, wrc, opc, adr;
    string rq;
    ins_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(acc == m_acc && fetch_pc == m_pc && ins_ready, "R11 idle", acc, m_acc);
    end
    ins_data  = ins;
    ins_valid = 1'b1;
    @(negedge clk);
    // busy: offer garbage that must be ignored
    ins_valid = 1'($urandom % 2);
    ins_data  = 8'($urandom);
    cnt = 0; rdc = 0; wrc = 0;
    while (!ins_ready && cnt < 20) begin
      cnt++;
      rdc += int'(dmem_rd);
      wrc += int'(dmem_wr);
      @(negedge clk);
    end
    ins_valid = 1'b0;
    opc = int'(ins[7:4]);
    adr = int'(ins[3:0]);
    m_pc = m_pc + 4'd1;
    case (opc)
      1: m_acc = m_mem[adr];
      2: m_mem[adr] = m_acc;
      3: m_acc = m_acc + m_mem[adr];
      4: m_pc = ins[3:0];
      5: m_acc = m_acc - m_mem[adr];
      6: m_acc = m_acc & m_mem[adr];
      default: ;
    endcase
    if (is_read_op(opc)) begin
      m_z = (m_acc == 8'd0);
      m_n = m_acc[7];
    end
    rq = (opc >= 7) ? "R9" : (opc == 1) ? "R4" : (opc == 2) ? "R5" :
         (opc == 4) ? "R8" : "R6";
    chk(cnt == exp_len(opc), "R3 busy length", cnt, exp_len(opc));
    chk(rdc == (is_read_op(opc) ? 1 : 0), "R4 read count", rdc, is_read_op(opc) ? 1 : 0);
    chk(wrc == (opc == 2 ? 1 : 0), "R5 write count", wrc, opc == 2 ? 1 : 0);
    chk(acc == m_acc, {rq, " acc"}, acc, m_acc);
    chk(zero_flag == m_z && neg_flag == m_n, "R7 flags", {zero_flag, neg_flag}, {m_z, m_n});
    chk(fetch_pc == m_pc, {rq, " R2 pc"}, fetch_pc, m_pc);
    chk(ext_mem[adr] == m_mem[adr], {rq, " R5 mem"}, ext_mem[adr], m_mem[adr]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // preload memory during reset
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: m_mem[i] = 8'h00;
        1: m_mem[i] = 8'h80;
        2: m_mem[i] = 8'hFF;
        3: m_mem[i] = 8'h01;
        default: m_mem[i] = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      endcase
      @(negedge clk);
      pre_we = 1'b1; pre_a = 4'(i); pre_d = m_mem[i];
    end
    @(negedge clk);
    pre_we = 1'b0;
    chk(acc == 8'd0 && !zero_flag && !neg_flag && fetch_pc == 4'd0 && ins_ready,
        "R1 in reset", {acc, zero_flag, neg_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc == 8'd0 && !zero_flag && !neg_flag && fetch_pc == 4'd0 && ins_ready,
        "R1 after reset", {acc, fetch_pc}, 0);
    m_acc = 8'd0; m_z = 1'b0; m_n = 1'b0; m_pc = 4'd0;

    // directed corners
    run_ins(8'h11, 0);  // LOAD 0x80: negative
    run_ins(8'h10, 1);  // LOAD 0: zero
    run_ins(8'h12, 0);  // LOAD 0xFF
    run_ins(8'h33, 0);  // ADD 1: wraps to zero
    run_ins(8'h25, 2);  // STORE, flags hold
    run_ins(8'h53, 0);  // SUB 1: 0xFF negative
    run_ins(8'h61, 0);  // AND 0x80
    run_ins(8'h26, 0);  // STORE
    run_ins(8'h00, 0);  // NOP
    run_ins(8'h7A, 1);  // unused opcode
    run_ins(8'hF3, 0);  // unused opcode
    run_ins(8'h49, 0);  // JUMP 9
    run_ins(8'h4F, 0);  // JUMP 15
    run_ins(8'h00, 0);  // pc wraps to 0
    run_ins(8'h16, 0);  // LOAD back stored word

    // random mix
    for (int k = 0; k < 300; k++) begin
      run_ins(8'($urandom), int'($urandom % 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule